// File: doc/BRIEF.md
# Layer priority scanline compositor

This block builds one display line from up to four background layers. When a line starts it walks sixteen visit slots: priority value 0 up to 3, and within each priority value layer index 0 up to 3. A slot is drawn only when the layer's enable bit is set and its programmed priority equals the slot's priority value. For each drawn layer the block steps a column index `fetch_x` across the line, and the layer sources answer in the same cycle with a 15-bit colour and an opaque flag for every layer. An opaque pixel claims a line-buffer entry that is still free. An entry that is already claimed keeps its colour, so the first layer visited wins.

Once the last slot has been handled, the block emits the line. Each entry becomes a 32-bit RGBA word, and an entry that no layer claimed takes the backdrop colour. Each word is written at `line * WIDTH + x` on one of two screens. The same pass returns every entry to the free state, ready for the next line. When the display is off, the line is filled with all-ones instead. A parameter states whether the block is the primary or the secondary engine, and that sets which screen the swap flag selects.

Top module: `lpc_compositor`

## Requirements
- R1: After reset `fb_we` is low and no framebuffer write occurs until `line_start` is pulsed.
- R2: A column takes the colour of the first opaque pixel in visit order: ascending priority value (2-bit field `layer_prio[2*l+1:2*l]` for layer l), with ties broken by ascending layer index.
- R3: A layer whose bit in `layer_en` is 0 never contributes a pixel.
- R4: A pixel with its `pix_opaque` bit at 0 leaves the entry unchanged, so a later-visited opaque layer can still fill that column.
- R5: A column that no layer covers is written as backdrop BGR555 0xAAAA, which is RGBA 0x52AD52FF.
- R6: Every line-buffer entry is free again after a line is emitted, so no colour carries over to the next line.
- R7: A line produces exactly WIDTH writes, one per cycle, at `fb_addr = line_num * WIDTH + x` for x running from 0 to WIDTH-1.
- R8: `fb_top` equals `swap` for the primary engine (SECONDARY=0) and the inverse of `swap` for the secondary engine.
- R9: With `disp_on` at 0 the line is written as WIDTH words of 0xFFFFFFFF at the same addresses.
- R10: Colour conversion takes red from bits 4:0, green from 9:5 and blue from 14:10 of `pix_bgr`. Each 5-bit channel c widens to {c, c[4:2]}, and the word is {R, G, B, 8'hFF}.
- R11: `line_num`, `disp_on`, `swap`, `layer_en` and `layer_prio` are captured at `line_start`. A `line_start` that arrives while a line is still in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse that begins composing a line |
| line_num | input | $clog2(HEIGHT) | Line index for address generation |
| disp_on | input | 1 | 1 = compose the layers, 0 = fill the line with white |
| swap | input | 1 | Screen swap flag |
| layer_en | input | 4 | Per-layer enable mask |
| layer_prio | input | 8 | Four 2-bit priority values, layer 0 in bits 1:0 |
| fetch_x | output | $clog2(WIDTH) | Column the layer sources must present |
| pix_bgr | input | 60 | Four 15-bit BGR555 pixels for `fetch_x`, layer 0 in bits 14:0 |
| pix_opaque | input | 4 | Per-layer opaque flag for `fetch_x` |
| fb_top | output | 1 | 1 = write targets the top screen |
| fb_addr | output | $clog2(WIDTH*HEIGHT) | Framebuffer word offset |
| fb_data | output | 32 | RGBA pixel word |
| fb_we | output | 1 | Framebuffer write strobe |

## Verification
Damage to the line buffer shows up as a wrong colour in the line that is being emitted. If an entry is not freed, the fault surfaces in the next line, as a stale colour where the backdrop is expected. An error in slot ordering or in the enable/priority match gives a wrong winner in every column where two opaque layers overlap. The sweep therefore runs every enable mask against priority patterns that include all-equal priorities, which makes the index tiebreak decide. A fault in the phase sequencing changes the count or the addresses of the writes in the same line, and the per-write address checks catch it at once.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    localparam int LAYERS = 4;
    localparam int PRIO_W = 2;
    localparam int LIDX_W = 2;
    localparam int SLOT_W = PRIO_W + LIDX_W;
    localparam int BGR_W  = 15;

    localparam logic [15:0] BACKDROP_BGR = 16'hAAAA;
    localparam logic [31:0] WHITE_RGBA   = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ENT_UNSET  = 2'd0,
        ENT_BG     = 2'd1,
        ENT_OBJ    = 2'd2,
        ENT_HIDDEN = 2'd3
    } ent_state_e;

    typedef struct packed {
        ent_state_e        st;
        logic [BGR_W-1:0]  bgr;
    } line_ent_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_DRAW = 2'd2,
        PH_EMIT = 2'd3
    } phase_e;

    function automatic logic [7:0] widen5(input logic [4:0] c);
        return {c, c[4:2]};
    endfunction

    function automatic logic [31:0] bgr_to_rgba(input logic [BGR_W-1:0] w);
        return {widen5(w[4:0]), widen5(w[9:5]), widen5(w[14:10]), 8'hFF};
    endfunction

    function automatic logic ent_covered(input ent_state_e s);
        return (s == ENT_BG) || (s == ENT_OBJ);
    endfunction

endpackage

// File: rtl/lpc_slot_sched.sv
module lpc_slot_sched
    import lpc_pkg::*;
(
    input  logic [SLOT_W-1:0]        slot,
    input  logic [LAYERS-1:0]        en,
    input  logic [LAYERS*PRIO_W-1:0] prio,
    output logic                     hit
);
    logic [LAYERS-1:0] match;

    for (genvar l = 0; l < LAYERS; l++) begin : g_match
        assign match[l] = en[l]
                       && (prio[l*PRIO_W +: PRIO_W] == slot[SLOT_W-1 -: PRIO_W])
                       && (slot[LIDX_W-1:0] == LIDX_W'(l));
    end

    assign hit = |match;
endmodule

// File: rtl/lpc_line_buf.sv
module lpc_line_buf
    import lpc_pkg::*;
#(
    parameter int WIDTH = 256,
    localparam int XW   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [XW-1:0]    wr_x,
    input  logic [BGR_W-1:0] wr_bgr,
    input  logic             clr_en,
    input  logic [XW-1:0]    clr_x,
    input  logic [XW-1:0]    rd_x,
    output line_ent_t        rd_ent
);
    line_ent_t [WIDTH-1:0] ents;

    for (genvar i = 0; i < WIDTH; i++) begin : g_ent
        line_ent_t ent_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q.st  <= ENT_UNSET;
                ent_q.bgr <= '0;
            end else if (clr_en && clr_x == XW'(i)) begin
                ent_q.st  <= ENT_UNSET;
            end else if (wr_en && wr_x == XW'(i) && ent_q.st == ENT_UNSET) begin
                ent_q.st  <= ENT_BG;
                ent_q.bgr <= wr_bgr;
            end
        end
        assign ents[i] = ent_q;
    end

    assign rd_ent = ents[rd_x];
endmodule

// File: rtl/lpc_px_out.sv
module lpc_px_out
    import lpc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_in,
    input  logic          white_in,
    input  logic          top_in,
    input  logic [AW-1:0] addr_in,
    input  line_ent_t     ent_in,
    output logic          fb_top,
    output logic [AW-1:0] fb_addr,
    output logic [31:0]   fb_data,
    output logic          fb_we
);
    logic [31:0] word;

    always_comb begin
        if (white_in)
            word = WHITE_RGBA;
        else if (ent_covered(ent_in.st))
            word = bgr_to_rgba(ent_in.bgr);
        else
            word = bgr_to_rgba(BACKDROP_BGR[BGR_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_we   <= 1'b0;
            fb_top  <= 1'b0;
            fb_addr <= '0;
            fb_data <= '0;
        end else begin
            fb_we <= valid_in;
            if (valid_in) begin
                fb_top  <= top_in;
                fb_addr <= addr_in;
                fb_data <= word;
            end
        end
    end
endmodule

// File: rtl/lpc_compositor.sv
module lpc_compositor
    import lpc_pkg::*;
#(
    parameter int WIDTH     = 256,
    parameter int HEIGHT    = 192,
    parameter bit SECONDARY = 1'b0,
    localparam int XW = $clog2(WIDTH),
    localparam int LW = $clog2(HEIGHT),
    localparam int AW = $clog2(WIDTH * HEIGHT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     line_start,
    input  logic [LW-1:0]            line_num,
    input  logic                     disp_on,
    input  logic                     swap,
    input  logic [LAYERS-1:0]        layer_en,
    input  logic [LAYERS*PRIO_W-1:0] layer_prio,
    output logic [XW-1:0]            fetch_x,
    input  logic [LAYERS*BGR_W-1:0]  pix_bgr,
    input  logic [LAYERS-1:0]        pix_opaque,
    output logic                     fb_top,
    output logic [AW-1:0]            fb_addr,
    output logic [31:0]              fb_data,
    output logic                     fb_we
);
    localparam logic [XW-1:0]     X_LAST    = XW'(WIDTH - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = '1;

    phase_e                    phase;
    logic [SLOT_W-1:0]         slot_q;
    logic [XW-1:0]             x_q;
    logic [LW-1:0]             line_q;
    logic                      on_q;
    logic                      swap_q;
    logic [LAYERS-1:0]         en_q;
    logic [LAYERS*PRIO_W-1:0]  prio_q;
    logic                      slot_hit;
    logic                      busy;

    logic [LIDX_W-1:0]         cur_layer;
    logic                      draw_wr;
    logic [BGR_W-1:0]          draw_bgr;
    logic [AW-1:0]             emit_addr;
    line_ent_t                 rd_ent;

    assign busy      = (phase != PH_IDLE);
    assign cur_layer = slot_q[LIDX_W-1:0];
    assign fetch_x   = x_q;

    lpc_slot_sched u_sched (
        .slot (slot_q),
        .en   (en_q),
        .prio (prio_q),
        .hit  (slot_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            slot_q <= '0;
            x_q    <= '0;
            line_q <= '0;
            on_q   <= 1'b0;
            swap_q <= 1'b0;
            en_q   <= '0;
            prio_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (line_start) begin
                        line_q <= line_num;
                        on_q   <= disp_on;
                        swap_q <= swap;
                        en_q   <= layer_en;
                        prio_q <= layer_prio;
                        slot_q <= '0;
                        x_q    <= '0;
                        phase  <= disp_on ? PH_SCAN : PH_EMIT;
                    end
                end
                PH_SCAN: begin
                    if (slot_hit) begin
                        x_q   <= '0;
                        phase <= PH_DRAW;
                    end else if (slot_q == SLOT_LAST) begin
                        x_q   <= '0;
                        phase <= PH_EMIT;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                PH_DRAW: begin
                    if (x_q == X_LAST) begin
                        x_q <= '0;
                        if (slot_q == SLOT_LAST) begin
                            phase <= PH_EMIT;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                            phase  <= PH_SCAN;
                        end
                    end else begin
                        x_q <= x_q + 1'b1;
                    end
                end
                PH_EMIT: begin
                    if (x_q == X_LAST) begin
                        x_q   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        x_q <= x_q + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign draw_wr   = (phase == PH_DRAW) && pix_opaque[cur_layer];
    assign draw_bgr  = pix_bgr[cur_layer*BGR_W +: BGR_W];
    assign emit_addr = AW'(line_q) * AW'(WIDTH) + AW'(x_q);

    lpc_line_buf #(.WIDTH(WIDTH)) u_lbuf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (draw_wr),
        .wr_x   (x_q),
        .wr_bgr (draw_bgr),
        .clr_en (phase == PH_EMIT),
        .clr_x  (x_q),
        .rd_x   (x_q),
        .rd_ent (rd_ent)
    );

    lpc_px_out #(.AW(AW)) u_out (
        .clk      (clk),
        .rst      (rst),
        .valid_in (phase == PH_EMIT),
        .white_in (!on_q),
        .top_in   (swap_q ^ SECONDARY),
        .addr_in  (emit_addr),
        .ent_in   (rd_ent),
        .fb_top   (fb_top),
        .fb_addr  (fb_addr),
        .fb_data  (fb_data),
        .fb_we    (fb_we)
    );
endmodule

// File: rtl/lpc_compositor_chk.sv
module lpc_compositor_chk #(
    parameter int WIDTH  = 256,
    parameter int HEIGHT = 192,
    parameter int LW     = 8,
    parameter int AW     = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          line_start,
    input logic          busy,
    input logic [LW-1:0] line_q,
    input logic          fb_top,
    input logic [AW-1:0] fb_addr,
    input logic [31:0]   fb_data,
    input logic          fb_we
);
    // R7
    addr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (32'(fb_addr) < WIDTH * HEIGHT));

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_we && $past(fb_we)) |-> (fb_addr == $past(fb_addr) + 1'b1));

    // R8
    screen_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_we && $past(fb_we)) |-> $stable(fb_top));

    // R10
    alpha_opaque_chk: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (fb_data[7:0] == 8'hFF));

    // R11
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && line_start) |=> $stable(line_q));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !fb_we);
endmodule

bind lpc_compositor lpc_compositor_chk #(
    .WIDTH  (WIDTH),
    .HEIGHT (HEIGHT),
    .LW     (LW),
    .AW     (AW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .busy       (busy),
    .line_q     (line_q),
    .fb_top     (fb_top),
    .fb_addr    (fb_addr),
    .fb_data    (fb_data),
    .fb_we      (fb_we)
);

// File: tb/lpc_compositor_tb.sv
module lpc_compositor_tb;
    localparam int W  = 16;
    localparam int H  = 8;
    localparam int XW = $clog2(W);
    localparam int LW = $clog2(H);
    localparam int AW = $clog2(W * H);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_start = 1'b0;
    logic [LW-1:0] line_num = '0;
    logic disp_on = 1'b0;
    logic swap = 1'b0;
    logic [3:0] layer_en = '0;
    logic [7:0] layer_prio = '0;
    int seed = 0;

    logic [XW-1:0] fx_a, fx_b;
    logic [59:0] bgr_a, bgr_b;
    logic [3:0] op_a, op_b;
    logic top_a, top_b, we_a, we_b;
    logic [AW-1:0] addr_a, addr_b;
    logic [31:0] data_a, data_b;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    function automatic bit pix_op(input int l, input int x, input int s);
        return ((x * (l + 1) + s) % 5) != 0;
    endfunction

    function automatic logic [14:0] pix_col(input int l, input int x, input int s);
        return 15'((l * 4099 + x * 331 + s * 97) & 32'h7FFF);
    endfunction

    function automatic logic [7:0] grow(input int c);
        return 8'((c << 3) | (c >> 2));
    endfunction

    function automatic logic [31:0] to_rgba(input logic [14:0] c);
        int r, g, b;
        r = c % 32;
        g = (c / 32) % 32;
        b = (c / 1024) % 32;
        return {grow(r), grow(g), grow(b), 8'hFF};
    endfunction

    always_comb begin
        for (int l = 0; l < 4; l++) begin
            bgr_a[l*15 +: 15] = pix_col(l, int'(fx_a), seed);
            op_a[l]           = pix_op(l, int'(fx_a), seed);
            bgr_b[l*15 +: 15] = pix_col(l, int'(fx_b), seed);
            op_b[l]           = pix_op(l, int'(fx_b), seed);
        end
    end

    lpc_compositor #(.WIDTH(W), .HEIGHT(H), .SECONDARY(1'b0)) u_dut (
        .clk(clk), .rst(rst), .line_start(line_start), .line_num(line_num),
        .disp_on(disp_on), .swap(swap), .layer_en(layer_en), .layer_prio(layer_prio),
        .fetch_x(fx_a), .pix_bgr(bgr_a), .pix_opaque(op_a),
        .fb_top(top_a), .fb_addr(addr_a), .fb_data(data_a), .fb_we(we_a)
    );

    lpc_compositor #(.WIDTH(W), .HEIGHT(H), .SECONDARY(1'b1)) u_dut_b (
        .clk(clk), .rst(rst), .line_start(line_start), .line_num(line_num),
        .disp_on(disp_on), .swap(swap), .layer_en(layer_en), .layer_prio(layer_prio),
        .fetch_x(fx_b), .pix_bgr(bgr_b), .pix_opaque(op_b),
        .fb_top(top_b), .fb_addr(addr_b), .fb_data(data_b), .fb_we(we_b)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic run_line(input int ln, input bit on, input bit sw, input logic [3:0] en,
                            input logic [7:0] pr, input int s, input bit glitch);
        logic [31:0] expd [W];
        string tagd [W];
        int got, cyc;
        for (int x = 0; x < W; x++) begin
            bit found = 1'b0;
            logic [14:0] c = '0;
            for (int p = 0; p < 4; p++)
                for (int l = 0; l < 4; l++)
                    if (!found && en[l] && int'(pr[l*2 +: 2]) == p && pix_op(l, x, s)) begin
                        found = 1'b1;
                        c = pix_col(l, x, s);
                    end
            if (!on) begin
                expd[x] = 32'hFFFF_FFFF; tagd[x] = "R9";
            end else if (found) begin
                expd[x] = to_rgba(c);    tagd[x] = "R2 R3 R4 R10";
            end else begin
                expd[x] = 32'h52AD_52FF; tagd[x] = "R5 R6";
            end
        end
        @(negedge clk);
        line_num = LW'(ln); disp_on = on; swap = sw; layer_en = en; layer_prio = pr;
        seed = s; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        got = 0; cyc = 0;
        while (got < W && cyc < 3000) begin
            if (we_a) begin
                check(addr_a == AW'(ln * W + got), "R7 R11 address", 32'(addr_a), 32'(ln * W + got));
                check(data_a == expd[got], tagd[got], data_a, expd[got]);
                check(top_a == sw, "R8 primary screen", 32'(top_a), 32'(sw));
                check(we_b && top_b == !sw && data_b == expd[got] && addr_b == addr_a,
                      "R8 secondary engine", {data_b[31:1], top_b}, {expd[got][31:1], !sw});
                got++;
            end
            cyc++;
            if (glitch && cyc == 3) begin
                line_start = 1'b1; line_num = LW'(ln ^ 1); layer_en = ~en;
                swap = ~sw; disp_on = ~on; layer_prio = ~pr;
            end
            if (glitch && cyc == 4) line_start = 1'b0;
            @(negedge clk);
        end
        check(got == W, "R7 write count", 32'(got), 32'(W));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [7:0] pats [8] = '{8'hE4, 8'h1B, 8'h00, 8'hFF, 8'h4E, 8'hB1, 8'h55, 8'hA0};
        int it;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: quiet after reset
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(!we_a && !we_b, "R1 no write after reset", 32'(we_a), 32'd0);
        end
        // R2 R3 R4 R5 R10: sweep all masks over priority patterns
        it = 0;
        for (int p = 0; p < 8; p++)
            for (int e = 0; e < 16; e++) begin
                run_line(it % H, 1'b1, it[0], 4'(e), pats[p], it * 7 + 3, 1'b0);
                it++;
            end
        // R6: full coverage line followed by an empty one
        run_line(5, 1'b1, 1'b0, 4'hF, 8'h00, 11, 1'b0);
        run_line(6, 1'b1, 1'b0, 4'h0, 8'h00, 12, 1'b0);
        // R9: display off on both swap settings
        run_line(2, 1'b0, 1'b0, 4'hF, 8'hE4, 4, 1'b0);
        run_line(7, 1'b0, 1'b1, 4'hF, 8'hE4, 5, 1'b0);
        // R11: start pulse during an active line is ignored
        run_line(3, 1'b1, 1'b1, 4'b0101, 8'h1B, 9, 1'b1);
        run_line(4, 1'b0, 1'b0, 4'hF, 8'h00, 2, 1'b1);
        for (int i = 0; i < 6 * W; i++) begin
            @(negedge clk);
            check(!we_a, "R11 no extra line", 32'(we_a), 32'd0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule